// File: doc/BRIEF.md
# Oversampling Bit-Timing Recovery Loop

This block recovers bit timing from a filtered serial receive line. It runs on a system clock that is twelve times the nominal bit rate, so each bit cell spans twelve clocks. The raw line first passes through a two-flop synchronizer and a three-sample majority filter. A phase counter then steps through the twelve positions of each bit cell. Each transition on the filtered line pulls the counter toward the expected bit boundary, by at most one step per bit.

Once per recovered bit, at the centre of the cell, the block raises a one-clock receive enable and presents the sampled data bit on the same clock. A downstream shift register uses that enable to qualify its shifts. It is an enable, not a separate clock. A sync flag shows whether recent transitions have stayed close to the expected boundary. Nothing beyond the bit timing is decoded here.

Top module: `dpll_bitsync`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `rx_en` is 0, `rx_bit` is 0 and `in_sync` is 0. The phase counter restarts at position 0.
- R2: The line is synchronized through two flops, then filtered by a majority vote over the last three synchronized samples. A single-clock pulse against a steady level never reaches `rx_bit` and never counts as a transition.
- R3: With no transitions on the filtered line, the counter free-runs. `rx_en` then pulses exactly every 12 clocks, and the first pulse after reset is on the 7th clock.
- R4: `rx_en` is high for exactly one clock per bit, on the clock after the counter reaches mid-bit position 6. On that clock `rx_bit` holds the filtered level seen at position 6, and it keeps that value until the next pulse.
- R5: A transition seen at counter positions 1 to 5 is late, and the counter holds its position for one clock.
- R6: A transition seen at counter positions 6 to 11 is early, and the counter advances by two positions (modulo 12) for one clock.
- R7: A transition at position 0 causes no correction. At most one correction is applied between two passes through mid-bit position 6.
- R8: A transition is in tolerance when it is seen at position 11, 0 or 1. `in_sync` rises on the clock after the 8th consecutive in-tolerance transition.
- R9: `in_sync` falls on the clock after the 4th consecutive out-of-tolerance transition. Bit cells with no transition leave both run counts and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 12x the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial receive data, asynchronous to clk |
| rx_en | output | 1 | One-clock enable at each recovered bit centre |
| rx_bit | output | 1 | Recovered data bit, valid while rx_en is high |
| in_sync | output | 1 | Bit timing lock indicator |

## Verification
The bench drives streams with bit periods of 11, 12 and 13 clocks, so the loop has to keep correcting in both directions. A design that held when it should advance, or that corrected more than once per bit, would drift out of step and put `rx_en` on the wrong clocks. Single-clock glitches on a steady line check the filter: a weaker filter would flip `rx_bit` or count a false transition. Aligned alternating data and fast toggling data check lock and unlock. An off-by-one in either run count would move the `in_sync` edge by one transition, and a flag that reacted to empty bit cells would drop lock on long runs of identical bits.

// File: rtl/dpll_pkg.sv
// Package dpll_pkg
// Shared helpers for the bit-timing recovery loop.
// Assumes nothing beyond plain synthesizable logic.
package dpll_pkg;

    // Returns the majority value of three samples.
    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/dpll_cond.sv
// Module dpll_cond
// Brings the asynchronous line into the clock domain and removes
// single-clock glitches with a three-sample majority vote.
// Assumes SYNC_STAGES >= 2 and a synchronous active-low reset.
module dpll_cond
    import dpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic filt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             win_q;

    // Synchronizer chain and sample window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            win_q  <= '0;
            filt_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
            filt_o <= maj3(win_q);
        end
    end

    // R2: the filter output may only move toward a value that at least two window samples held
    assert_majority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> (filt_o ? ($countones($past(win_q)) >= 2)
                                     : ($countones($past(win_q)) <= 1)));
endmodule

// File: rtl/dpll_phase.sv
// Module dpll_phase
// Phase counter over one bit cell, corrected by transitions on the
// filtered line. Produces the mid-bit enable and the sampled bit.
// Assumes OSR >= 4 and that position 0 is the expected boundary.
module dpll_phase #(
    parameter int OSR = 12,
    parameter int MID = 6,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            filt_i,
    output logic            en_o,
    output logic            bit_o,
    output logic            edge_o,
    output logic            tol_o,
    output logic [PH_W-1:0] ph_o
);
    logic [PH_W-1:0] ph_q, ph_d;
    logic            filt_d_q;
    logic            done_q;
    logic            allow, late, early;
    logic [PH_W:0]   step, sum;

    assign edge_o = filt_i ^ filt_d_q;
    assign tol_o  = (ph_q == '0) || (ph_q == PH_W'(1)) || (ph_q == PH_W'(OSR-1));
    assign ph_o   = ph_q;

    // Choose the step size from the position of any transition
    always_comb begin
        allow = !done_q || (ph_q == PH_W'(MID));
        late  = edge_o && allow && (ph_q != '0) && (ph_q < PH_W'(MID));
        early = edge_o && allow && (ph_q >= PH_W'(MID));
        step  = late ? '0 : (early ? (PH_W+1)'(2) : (PH_W+1)'(1));
        sum   = {1'b0, ph_q} + step;
        ph_d  = (sum >= (PH_W+1)'(OSR)) ? PH_W'(sum - (PH_W+1)'(OSR)) : sum[PH_W-1:0];
    end

    // Counter, correction flag, edge history and mid-bit outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            filt_d_q <= 1'b0;
            done_q   <= 1'b0;
            en_o     <= 1'b0;
            bit_o    <= 1'b0;
        end else begin
            ph_q     <= ph_d;
            filt_d_q <= filt_i;
            done_q   <= (late || early) ? 1'b1 : ((ph_q == PH_W'(MID)) ? 1'b0 : done_q);
            en_o     <= (ph_q == PH_W'(MID));
            if (ph_q == PH_W'(MID))
                bit_o <= filt_i;
        end
    end

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q < PH_W'(OSR));
    assert_en_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);
    assert_bit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> $stable(bit_o));
    assert_no_edge_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_o && ph_q != PH_W'(OSR-1)) |=> (ph_q == $past(ph_q) + PH_W'(1)));
    // R6, R7: without a transition no position is ever skipped
    assert_no_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_o && ph_q == PH_W'(OSR-1)) |=> (ph_q == '0));
endmodule

// File: rtl/dpll_lock.sv
// Module dpll_lock
// Tracks runs of in-tolerance and out-of-tolerance transitions and
// sets or clears the sync flag when a run is long enough.
// Assumes edge_i is a single-clock strobe per transition.
module dpll_lock #(
    parameter int LOCK_RUN   = 8,
    parameter int UNLOCK_RUN = 4,
    localparam int GW = $clog2(LOCK_RUN + 1),
    localparam int BW = $clog2(UNLOCK_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic tol_i,
    output logic sync_o
);
    logic [GW-1:0] good_q;
    logic [BW-1:0] bad_q;

    // Run counters and flag update on each transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
            bad_q  <= '0;
            sync_o <= 1'b0;
        end else if (edge_i) begin
            if (tol_i) begin
                bad_q <= '0;
                if (good_q < GW'(LOCK_RUN)) good_q <= good_q + GW'(1);
                if (good_q >= GW'(LOCK_RUN - 1)) sync_o <= 1'b1;
            end else begin
                good_q <= '0;
                if (bad_q < BW'(UNLOCK_RUN)) bad_q <= bad_q + BW'(1);
                if (bad_q >= BW'(UNLOCK_RUN - 1)) sync_o <= 1'b0;
            end
        end
    end

    assert_rise_on_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(edge_i && tol_i));
    assert_fall_on_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(edge_i && !tol_i));
    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> $stable(sync_o));
endmodule

// File: rtl/dpll_bitsync.sv
// Module dpll_bitsync
// Top of the bit-timing recovery loop: conditioner, phase tracker and
// lock monitor. The clock is assumed to run at OSR times the bit rate.
module dpll_bitsync #(
    parameter int OSR         = 12,
    parameter int MID         = 6,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_RUN    = 8,
    parameter int UNLOCK_RUN  = 4,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic rx_en,
    output logic rx_bit,
    output logic in_sync
);
    logic            filt, edge_s, tol_s;
    logic [PH_W-1:0] ph_unused;

    dpll_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .line_i(rx_line), .filt_o(filt));

    dpll_phase #(.OSR(OSR), .MID(MID)) u_phase (
        .clk(clk), .rst_n(rst_n), .filt_i(filt), .en_o(rx_en), .bit_o(rx_bit),
        .edge_o(edge_s), .tol_o(tol_s), .ph_o(ph_unused));

    dpll_lock #(.LOCK_RUN(LOCK_RUN), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_s), .tol_i(tol_s), .sync_o(in_sync));

    // R1: the first clock after reset shows all outputs cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rx_en && !rx_bit && !in_sync));
endmodule

// File: tb/tb_dpll_bitsync.sv
module tb_dpll_bitsync;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b0;
    logic rx_en, rx_bit, in_sync;
    int   checks = 0;
    int   fails = 0;
    bit   cmp_on = 1'b0;
    int   cyc = 0;

    always #10 clk = ~clk;

    dpll_bitsync dut (.clk(clk), .rst_n(rst_n), .rx_line(rx_line),
                      .rx_en(rx_en), .rx_bit(rx_bit), .in_sync(in_sync));

    // Reference model written from the requirements
    logic m_s1, m_s2, m_filt, m_fd, m_done, m_rxc, m_bit, m_sync;
    logic [2:0] m_win;
    int m_ph, m_good, m_bad;

    function automatic int next_ph(int ph, bit edg, bit done);
        bit allow = !done || ph == 6;
        if (edg && allow && ph >= 1 && ph <= 5) return ph;           // R5
        if (edg && allow && ph >= 6) return (ph + 2) % 12;           // R6
        return (ph + 1) % 12;                                         // R7
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_win <= 0; m_filt <= 0; m_fd <= 0;
            m_ph <= 0; m_done <= 0; m_rxc <= 0; m_bit <= 0;
            m_good <= 0; m_bad <= 0; m_sync <= 0;
        end else begin
            bit edg, allow, corr, tol;
            edg = m_filt != m_fd;
            allow = !m_done || m_ph == 6;
            corr = edg && allow && m_ph != 0;
            tol = m_ph == 11 || m_ph == 0 || m_ph == 1;
            m_s1 <= rx_line; m_s2 <= m_s1;
            m_win <= {m_win[1:0], m_s2};
            m_filt <= (m_win[0] + m_win[1] + m_win[2]) >= 2;
            m_fd <= m_filt;
            m_ph <= next_ph(m_ph, edg, m_done);
            m_done <= corr ? 1'b1 : (m_ph == 6 ? 1'b0 : m_done);
            m_rxc <= m_ph == 6;
            if (m_ph == 6) m_bit <= m_filt;
            if (edg && tol) begin
                m_bad <= 0; m_good <= (m_good < 8) ? m_good + 1 : 8;
                if (m_good >= 7) m_sync <= 1;                         // R8
            end else if (edg) begin
                m_good <= 0; m_bad <= (m_bad < 4) ? m_bad + 1 : 4;
                if (m_bad >= 3) m_sync <= 0;                          // R9
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cyc);
        end
    endtask

    // Cycle comparison against the model, sampled on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cmp_on && rst_n) begin
            check(rx_en == m_rxc, "R4 rx_en timing (tracking R5 R6 R7)", rx_en, m_rxc);
            if (m_rxc) check(rx_bit == m_bit, "R4 rx_bit value", rx_bit, m_bit);
            check(in_sync == m_sync, "R8/R9 in_sync", in_sync, m_sync);
        end
    end

    // Drives n bits of the given period; random data or alternating
    task automatic send(input int n, input int period, input bit rnd);
        bit v = rx_line;
        for (int i = 0; i < n; i++) begin
            v = rnd ? 1'($urandom % 2) : ~v;
            rx_line = v;
            repeat (period) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int last, gap;
        bit glitch_bad;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!rx_en && !rx_bit && !in_sync, "R1 reset outputs", {rx_en, rx_bit, in_sync}, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check(!rx_en && !rx_bit && !in_sync, "R1 first clock after reset", {rx_en, rx_bit, in_sync}, 0);
        // R3: first pulse on the 7th clock, then every 12
        last = 1;
        for (int c = 2; c <= 60; c++) begin
            @(negedge clk);
            if (rx_en) begin
                gap = c - last;
                check(gap == ((last == 1) ? 6 : 12), "R3 free-run pulse spacing", gap, (last == 1) ? 6 : 12);
                last = c;
            end
        end
        // R2: single-clock glitches on a low line
        glitch_bad = 0;
        for (int g = 0; g < 10; g++) begin
            rx_line = 1'b1; @(negedge clk); rx_line = 1'b0;
            repeat (7 + g) @(negedge clk);
            if (rx_en && rx_bit) glitch_bad = 1;
        end
        repeat (30) begin @(negedge clk); if (rx_en && rx_bit) glitch_bad = 1; end
        check(!glitch_bad, "R2 glitch filtered", glitch_bad, 0);
        check(!in_sync, "R2 glitch not a transition", in_sync, 0);
        // R8: aligned alternating data locks
        send(40, 12, 1'b0);
        check(in_sync, "R8 lock on aligned data", in_sync, 1);
        // R9: idle line keeps lock
        repeat (200) @(negedge clk);
        check(in_sync, "R9 no transitions keep flag", in_sync, 1);
        // R5 R6: slow and fast streams stay locked
        send(60, 13, 1'b0);
        check(in_sync, "R5 lock held on slow data", in_sync, 1);
        send(60, 11, 1'b0);
        check(in_sync, "R6 lock held on fast data", in_sync, 1);
        // R9: fast toggling breaks lock
        send(60, 7, 1'b0);
        check(in_sync == m_sync, "R9 unlock on off-phase transitions", in_sync, m_sync);
        // Random data at mixed rates, compared every cycle
        for (int s = 0; s < 24; s++)
            send(150, 11 + ($urandom % 3), 1'b1);
        send(40, 12, 1'b0);
        check(in_sync, "R8 relock after random data", in_sync, 1);
        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule